// File: doc/BRIEF.md
# Dual 32-bit Interval Timer

The block holds two independent up-counters, a lower half and an upper half, each with its own counter register and period register, all reached through a simple single-cycle register bus. A shared control word gives each half a two-bit run mode: off, single-shot or repeating. A global word releases each half from reset and selects the timer arrangement. Only the split arrangement, with the halves running separately, is built. Each half drives its own event line when its counter meets its period. An optional compare register watches the lower counter and raises a third event line without disturbing the count.

A write lands at the rising clock edge on which it is presented. A read returns data combinationally in the same cycle, and reads have no side effects. The counter width is a parameter (32 by default), and counter and period values are zero-extended onto the 32-bit bus. A sticky status word records every event until software clears it.

Top module: `dual_timer`

## Requirements
- R1: After reset, every register reads 0 except the two period registers, which read all ones of the counter width. All three event outputs are low.
- R2: Global-control bit 0 (lower half) and bit 1 (upper half) are reset releases. While a half's bit is 0, its counter reads 0 and writes to that counter are overridden. Writing the bit to 0 clears the counter at that same edge.
- R3: A half counts only when global-control bits 3:2 equal 01. With any other value, both counters hold.
- R4: Single-shot mode (run mode 1) counts up by one per clock from the current value. At the edge where counter equals period, the counter goes to 0, the half's run-mode field becomes 0, and its event output is high for the following cycle.
- R5: Repeating mode (run mode 2) wraps the counter to 0 on each period match and keeps running. With period P starting from counter 0, an event appears every P+1 cycles.
- R6: Run modes 0 and 3 both stop the half. The counter holds its value and no event is raised.
- R7: Writing a counter register loads it at that edge. The load takes priority over the increment and the wrap in the same cycle.
- R8: The halves run independently. The lower run-mode field is at control bits 7:6 and the upper field is at bits 23:22.
- R9: When the compare unit is present, a running lower half whose counter equals the compare value raises the compare event for one cycle, and the lower counter continues counting.
- R10: Status bits at offset 0x2C are: bit 0 lower event, bit 1 upper event, bit 2 compare event. Each bit is set at the edge its event is raised and cleared by writing 1. A set and a clear at the same edge leave the bit set.
- R11: Register byte offsets: lower counter 0x10, upper counter 0x14, lower period 0x18, upper period 0x1C, run-mode control 0x20, global control 0x24, compare 0x28, status 0x2C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| evt_lo_o | output | 1 | Lower half event pulse |
| evt_hi_o | output | 1 | Upper half event pulse |
| evt_cmp_o | output | 1 | Compare event pulse |

## Verification
A period match and a software write to the status word can fall on the same edge. The bench runs the lower half in repeating mode with a short period and counts clocks so that a write-one-to-clear of bit 0 is captured on exactly the edge where the match happens. The status bit must read 1 afterwards. One cycle later, a clear with no match must take it to 0. A counter load that coincides with counting is also provoked, and the value read back must equal the loaded value, not the loaded value plus one.

// File: rtl/dtim_pkg.sv
package dtim_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 8'h10;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 8'h14;
  localparam logic [ADDR_W-1:0] A_PRD_LO = 8'h18;
  localparam logic [ADDR_W-1:0] A_PRD_HI = 8'h1C;
  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h20;
  localparam logic [ADDR_W-1:0] A_GCR    = 8'h24;
  localparam logic [ADDR_W-1:0] A_CMP    = 8'h28;
  localparam logic [ADDR_W-1:0] A_STS    = 8'h2C;

  localparam int EM_LO_LSB = 6;
  localparam int EM_HI_LSB = 22;

  localparam logic [1:0] EM_OFF  = 2'd0;
  localparam logic [1:0] EM_ONCE = 2'd1;
  localparam logic [1:0] EM_LOOP = 2'd2;

  localparam logic [1:0] ARR_SPLIT = 2'b01;
  localparam int GCR_W = 4;
  localparam int STS_W = 3;
endpackage

// File: rtl/dtim_half.sv
module dtim_half
  import dtim_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rel_i,
  input  logic          run_i,
  input  logic          cnt_we_i,
  input  logic          prd_we_i,
  input  logic          em_we_i,
  input  logic [CW-1:0] wdata_i,
  input  logic [1:0]    em_wdata_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] prd_o,
  output logic [1:0]    em_o,
  output logic          act_o,
  output logic          match_o,
  output logic          evt_o
);
  logic [CW-1:0] cnt_q, prd_q;
  logic [1:0]    em_q;
  logic          evt_q;
  logic          act, match;

  assign act   = run_i && (em_q == EM_ONCE || em_q == EM_LOOP);
  assign match = act && (cnt_q == prd_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!rel_i)    cnt_q <= '0;
    else if (cnt_we_i)  cnt_q <= wdata_i;
    else if (match)     cnt_q <= '0;
    else if (act)       cnt_q <= cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       prd_q <= '1;
    else if (prd_we_i) prd_q <= wdata_i;
  end

  // software write wins over the single-shot self-disable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         em_q <= EM_OFF;
    else if (em_we_i)                    em_q <= em_wdata_i;
    else if (match && em_q == EM_ONCE)   em_q <= EM_OFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= 1'b0;
    else         evt_q <= match;
  end

  assign cnt_o   = cnt_q;
  assign prd_o   = prd_q;
  assign em_o    = em_q;
  assign act_o   = act;
  assign match_o = match;
  assign evt_o   = evt_q;
endmodule

// File: rtl/dtim_cmp.sv
module dtim_cmp #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CW-1:0] wdata_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          act_i,
  output logic [CW-1:0] cmp_o,
  output logic          match_o,
  output logic          evt_o
);
  logic [CW-1:0] cmp_q;
  logic          evt_q, match;

  assign match = act_i && (cnt_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cmp_q <= '0;
    else if (we_i) cmp_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= 1'b0;
    else         evt_q <= match;
  end

  assign cmp_o   = cmp_q;
  assign match_o = match;
  assign evt_o   = evt_q;
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dtim_pkg::*;
#(
  parameter int CW      = 32,
  parameter bit HAS_CMP = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              evt_lo_o,
  output logic              evt_hi_o,
  output logic              evt_cmp_o
);
  localparam int NH = 2;

  logic             wr_en, rd_en;
  logic [GCR_W-1:0] gcr_q, gcr_d;
  logic [STS_W-1:0] sts_q, sts_set, sts_clr;
  logic             run_ok;

  logic [CW-1:0] cnt_v [NH];
  logic [CW-1:0] prd_v [NH];
  logic [1:0]    em_v  [NH];
  logic [NH-1:0] act_v, match_v, evt_v;

  logic [CW-1:0] cmp_v;
  logic          cmp_match, cmp_evt;

  assign wr_en = req_i && we_i;
  assign rd_en = req_i && !we_i;

  assign gcr_d  = (wr_en && addr_i == A_GCR) ? wdata_i[GCR_W-1:0] : gcr_q;
  assign run_ok = (gcr_q[3:2] == ARR_SPLIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gcr_q <= '0;
    else         gcr_q <= gcr_d;
  end

  for (genvar g = 0; g < NH; g++) begin : g_half
    localparam int EM_LSB = (g == 0) ? EM_LO_LSB : EM_HI_LSB;
    localparam logic [ADDR_W-1:0] A_CNT = (g == 0) ? A_CNT_LO : A_CNT_HI;
    localparam logic [ADDR_W-1:0] A_PRD = (g == 0) ? A_PRD_LO : A_PRD_HI;

    dtim_half #(.CW(CW)) u_half (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rel_i      (gcr_d[g]),
      .run_i      (gcr_q[g] && run_ok),
      .cnt_we_i   (wr_en && addr_i == A_CNT),
      .prd_we_i   (wr_en && addr_i == A_PRD),
      .em_we_i    (wr_en && addr_i == A_CTRL),
      .wdata_i    (wdata_i[CW-1:0]),
      .em_wdata_i (wdata_i[EM_LSB +: 2]),
      .cnt_o      (cnt_v[g]),
      .prd_o      (prd_v[g]),
      .em_o       (em_v[g]),
      .act_o      (act_v[g]),
      .match_o    (match_v[g]),
      .evt_o      (evt_v[g])
    );
  end

  if (HAS_CMP) begin : g_cmp
    dtim_cmp #(.CW(CW)) u_cmp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en && addr_i == A_CMP),
      .wdata_i (wdata_i[CW-1:0]),
      .cnt_i   (cnt_v[0]),
      .act_i   (act_v[0]),
      .cmp_o   (cmp_v),
      .match_o (cmp_match),
      .evt_o   (cmp_evt)
    );
  end else begin : g_nocmp
    assign cmp_v     = '0;
    assign cmp_match = 1'b0;
    assign cmp_evt   = 1'b0;
  end

  // set beats write-one-to-clear
  assign sts_set = {cmp_match, match_v[1], match_v[0]};
  assign sts_clr = (wr_en && addr_i == A_STS) ? wdata_i[STS_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~sts_clr) | sts_set;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      unique case (addr_i)
        A_CNT_LO: rdata_o = BUS_W'(cnt_v[0]);
        A_CNT_HI: rdata_o = BUS_W'(cnt_v[1]);
        A_PRD_LO: rdata_o = BUS_W'(prd_v[0]);
        A_PRD_HI: rdata_o = BUS_W'(prd_v[1]);
        A_CTRL:   rdata_o = (BUS_W'(em_v[0]) << EM_LO_LSB) |
                            (BUS_W'(em_v[1]) << EM_HI_LSB);
        A_GCR:    rdata_o = BUS_W'(gcr_q);
        A_CMP:    rdata_o = BUS_W'(cmp_v);
        A_STS:    rdata_o = BUS_W'(sts_q);
        default:  rdata_o = '0;
      endcase
    end
  end

  assign evt_lo_o  = evt_v[0];
  assign evt_hi_o  = evt_v[1];
  assign evt_cmp_o = cmp_evt;
endmodule

// File: rtl/dtim_chk.sv
module dtim_chk #(
  parameter int CW      = 32,
  parameter bit HAS_CMP = 1'b1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en,
  input logic [3:0]    gcr,
  input logic [CW-1:0] cnt_lo,
  input logic [CW-1:0] prd_lo,
  input logic [1:0]    em_lo,
  input logic          act_lo,
  input logic [CW-1:0] cmp_v,
  input logic [2:0]    sts,
  input logic          evt_lo,
  input logic          evt_hi,
  input logic          evt_cmp
);
  AST_HELD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gcr[0] |-> cnt_lo == '0);                                         // R2
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gcr[3:2] != 2'b01 && !wr_en) |=> $stable(cnt_lo));                // R3
  AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_lo && em_lo == 2'd1 && cnt_lo == prd_lo && !wr_en)
      |=> (em_lo == 2'd0 && cnt_lo == '0 && evt_lo));                  // R4
  AST_PRD_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_lo && em_lo == 2'd2 && cnt_lo == prd_lo && !wr_en)
      |=> (em_lo == 2'd2 && cnt_lo == '0 && evt_lo));                  // R5
  AST_DIS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gcr[0] && (em_lo == 2'd0 || em_lo == 2'd3) && !wr_en)
      |=> ($stable(cnt_lo) && !evt_lo));                               // R6
  AST_CMP_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_CMP && act_lo && cnt_lo == cmp_v && !wr_en) |=> evt_cmp);     // R9
  AST_STS_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_lo |-> sts[0]);                                                // R10
  AST_STS_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_hi |-> sts[1]);                                                // R10
  AST_STS_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_cmp |-> sts[2]);                                               // R10
endmodule

bind dual_timer dtim_chk #(.CW(CW), .HAS_CMP(HAS_CMP)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en   (wr_en),
  .gcr     (gcr_q),
  .cnt_lo  (cnt_v[0]),
  .prd_lo  (prd_v[0]),
  .em_lo   (em_v[0]),
  .act_lo  (act_v[0]),
  .cmp_v   (cmp_v),
  .sts     (sts_q),
  .evt_lo  (evt_lo_o),
  .evt_hi  (evt_hi_o),
  .evt_cmp (evt_cmp_o)
);

// File: tb/dual_timer_test.sv
module dual_timer_test;
  localparam int PERIOD = 10;
  localparam int CW     = 8;

  localparam logic [7:0] O_CNT_LO = 8'h10, O_CNT_HI = 8'h14;
  localparam logic [7:0] O_PRD_LO = 8'h18, O_PRD_HI = 8'h1C;
  localparam logic [7:0] O_CTRL = 8'h20, O_GCR = 8'h24;
  localparam logic [7:0] O_CMP = 8'h28, O_STS = 8'h2C;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        evt_lo_o, evt_hi_o, evt_cmp_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  dual_timer #(.CW(CW), .HAS_CMP(1'b1)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .evt_lo_o(evt_lo_o), .evt_hi_o(evt_hi_o), .evt_cmp_o(evt_cmp_o)
  );

  always #(PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1;
    d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog got timeout exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int bad_lo, bad_hi, bad_c;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state, R11 offsets
    rd(O_CNT_LO, v); chk("R1 cnt_lo", v, 0);
    rd(O_CNT_HI, v); chk("R1 cnt_hi", v, 0);
    rd(O_PRD_LO, v); chk("R1 prd_lo", v, 32'hFF);
    rd(O_PRD_HI, v); chk("R1 prd_hi", v, 32'hFF);
    rd(O_CTRL, v);   chk("R1 ctrl", v, 0);
    rd(O_GCR, v);    chk("R1 gcr", v, 0);
    rd(O_CMP, v);    chk("R1 cmp", v, 0);
    rd(O_STS, v);    chk("R1 sts", v, 0);
    chk("R1 evts", {29'd0, evt_cmp_o, evt_hi_o, evt_lo_o}, 0);

    // R5 / R8 sweep: lower period p, upper period p+3, both repeating
    for (int p = 0; p <= 12; p++) begin
      int q = p + 3;
      wr(O_GCR, 0); wr(O_PRD_LO, p); wr(O_PRD_HI, q);
      wr(O_CTRL, 0); wr(O_GCR, 32'h7); wr(O_CTRL, 32'h0080_0080);
      bad_lo = 0; bad_hi = 0;
      for (int k = 1; k <= 40; k++) begin
        @(negedge clk_i);
        if (evt_lo_o !== ((k % (p + 1)) == 0)) bad_lo++;
        if (evt_hi_o !== ((k % (q + 1)) == 0)) bad_hi++;
      end
      chk($sformatf("R5 lower period %0d mismatches", p), bad_lo, 0);
      chk($sformatf("R8 upper period %0d mismatches", q), bad_hi, 0);
      wr(O_CTRL, 0);
    end

    // R6 / R7 / R4 single shot from preloaded 4 up to period 10
    wr(O_GCR, 0); wr(O_PRD_LO, 10); wr(O_CTRL, 0); wr(O_GCR, 32'h5);
    wr(O_CNT_LO, 4);
    repeat (3) @(negedge clk_i);
    rd(O_CNT_LO, v); chk("R6 off holds preload", v, 4);
    wr(O_CTRL, 32'h40);
    bad_lo = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk_i);
      if (evt_lo_o !== (k == 7)) bad_lo++;
    end
    chk("R4 single pulse at cycle 7", bad_lo, 0);
    rd(O_CTRL, v);   chk("R4 mode self-cleared", v, 0);
    rd(O_CNT_LO, v); chk("R4 counter stopped at 0", v, 0);

    // R6 mode 3 holds
    wr(O_CTRL, 32'hC0); wr(O_CNT_LO, 7);
    bad_lo = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      if (evt_lo_o) bad_lo++;
    end
    rd(O_CNT_LO, v); chk("R6 mode 3 holds", v, 7);
    chk("R6 mode 3 no event", bad_lo, 0);

    // R3 arrangement field not 01
    wr(O_GCR, 32'h3); wr(O_CTRL, 32'h80);
    repeat (5) @(negedge clk_i);
    rd(O_CNT_LO, v); chk("R3 arrangement 00 holds", v, 7);

    // R2 lower reset bit cleared
    wr(O_GCR, 32'h6);
    rd(O_CNT_LO, v); chk("R2 cleared on reset bit", v, 0);
    wr(O_CNT_LO, 9);
    rd(O_CNT_LO, v); chk("R2 write overridden", v, 0);

    // R7 load beats increment
    wr(O_GCR, 0); wr(O_PRD_LO, 200); wr(O_GCR, 32'h5); wr(O_CTRL, 32'h80);
    repeat (10) @(negedge clk_i);
    wr(O_CNT_LO, 50);
    rd(O_CNT_LO, v); chk("R7 load value", v, 50);
    repeat (3) @(negedge clk_i);
    rd(O_CNT_LO, v); chk("R7 counts on from load", v, 53);

    // R9 compare at 12, period 30
    wr(O_GCR, 0); wr(O_PRD_LO, 30); wr(O_CMP, 12); wr(O_STS, 7);
    wr(O_CTRL, 0); wr(O_GCR, 32'h5); wr(O_CTRL, 32'h80);
    bad_c = 0; bad_lo = 0;
    for (int k = 1; k <= 31; k++) begin
      @(negedge clk_i);
      if (evt_cmp_o !== (k == 13)) bad_c++;
      if (evt_lo_o !== (k == 31)) bad_lo++;
      if (k == 13) begin
        rd(O_CNT_LO, v); chk("R9 counter keeps running", v, 13);
      end
    end
    chk("R9 compare pulse", bad_c, 0);
    chk("R9 period pulse", bad_lo, 0);
    wr(O_CTRL, 0);
    rd(O_STS, v); chk("R10 status set", v, 32'h5);
    wr(O_STS, 1);
    rd(O_STS, v); chk("R10 clear bit 0 only", v, 32'h4);

    // R10 set and clear on the same edge: period 4, match at edge 5
    wr(O_GCR, 0); wr(O_PRD_LO, 4); wr(O_STS, 7); wr(O_CTRL, 0);
    wr(O_GCR, 32'h5); wr(O_CTRL, 32'h80);
    repeat (4) @(negedge clk_i);
    wr(O_STS, 1);
    chk("R10 event with collision", {31'd0, evt_lo_o}, 1);
    rd(O_STS, v); chk("R10 set wins", v & 32'h1, 1);
    wr(O_STS, 1);
    rd(O_STS, v); chk("R10 clear alone", v & 32'h1, 0);
    wr(O_CTRL, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule